// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the bus-facing side of a small serial memory. It watches the clock and data lines of a two-wire bus, sampling them with a fast system clock. It finds start and stop conditions and decodes the device address byte that follows each start. It answers with an acknowledge, then steps through writes of one byte or many bytes and through reads of one byte or many bytes. It pulls the data line low through an enable output only and never drives it high.

The storage array and the timed write cycle are outside the block. A synchronous byte port with one cycle of read latency reaches the array. A level request goes to a separate write-cycle controller, and that controller answers with a one-cycle done pulse. The device address byte has a fixed type code and a direction bit. Its remaining three bits are split by parameter: some are compared with hard-wired select inputs, and the rest become the upper bits of the memory address.

Top module: `tws_mem_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After reset, or once a stop is seen, the block is idle and `sda_pull_o` is 0.
- R2: Bits 7..4 of the first byte after a start must be 1010, and bit 0 selects read (1) or write (0). A byte that the block accepts is acknowledged by holding `sda_pull_o` high for the whole ninth clock. If the type code does not match, the block gives no acknowledge and goes idle.
- R3: Let U = address width - 8. Device-address bit k (k = 1..3) is memory-address bit 7+k when k <= U. Otherwise it must equal `sel_i[k-1]`. With 512 bytes, bit 1 is address bit 8 and bits 3..2 are compared with `sel_i[2:1]`. With 256 bytes all three bits are compared, and with 2048 bytes none are.
- R4: After a write-mode device address, the next byte is acknowledged. It becomes the low eight bits of the address pointer, and the upper bits come from the device address.
- R5: Each later data byte is acknowledged and written once through `mem_we_o` at the pointer. After that, only the low log2(PAGE_BYTES) pointer bits advance, and they wrap inside the page.
- R6: A stop after at least one data byte raises `wr_req_o`, and it stays high until `wr_done_i`. A write with an address but no data (a dummy write) raises no request.
- R7: While `wr_req_o` is high, no device address is acknowledged. The first matching address after `wr_done_i` is acknowledged.
- R8: A read sends the byte at the pointer MSB first, with each bit changing after an SCL fall. The pointer then advances by one across the whole memory, wrapping from the last byte to 0. Bytes continue while the host acknowledges, and output stops when the host leaves the ninth bit high.
- R9: A read-mode address with no word-address phase (a current-address read) starts at the pointer left by the last access, which is that address plus one. The upper bits of the device address do not change the pointer here.
- R10: A start or stop in the middle of a byte abandons the transfer and drops the partial byte, so nothing is written. A start then begins a new device-address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sel_i | input | 3 | Hard-wired select inputs compared with the device address |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array address (the pointer) |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after address |
| wr_req_o | output | 1 | Write cycle requested and pending |
| wr_done_i | input | 1 | One-cycle pulse: write cycle finished |

## Verification
The bench uses 512 bytes and 16-byte pages, so the direction bit, the single upper-address bit and the compared select bits are all exercised. A table of single-byte writes, each read back at once, covers the first and last bytes of each 256-byte half, which separates a lost upper-address bit from a wrong low byte. A 20-byte page write that starts near the end of a page reveals whether the pointer wraps inside the page or carries into the next one. A sequential read across the top of memory checks that a read pointer wraps the whole memory. Polling during a pending write, select and type mismatches, dummy writes and transfers cut short mid-byte each have a visibly different acknowledge pattern, or leave memory contents that differ.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } tws_state_t;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_LOAD,
        PTR_PAGE_INC,
        PTR_LIN_INC
    } ptr_op_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } tws_bus_ev_t;

    // Bits at or above up_w are compared with the select inputs.
    function automatic logic sel_match(input logic [2:0] dev_bits,
                                       input logic [2:0] sel,
                                       input int unsigned up_w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (i >= int'(up_w) && dev_bits[i] != sel[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/tws_line_cond.sv
module tws_line_cond
    import tws_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output tws_bus_ev_t ev_o
);

    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_prev;
    logic       sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    always_comb begin
        ev_o.scl   = scl_sync[1];
        ev_o.sda   = sda_sync[1];
        ev_o.rise  = scl_sync[1] & ~scl_prev;
        ev_o.fall  = ~scl_sync[1] & scl_prev;
        ev_o.start = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
        ev_o.stop  = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.rise, ev_o.fall, ev_o.start, ev_o.stop})); // R1

endmodule

// File: rtl/tws_addr_ptr.sv
module tws_addr_ptr
    import tws_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_op_t           op_i,
    input  logic [ADDR_W-1:0] load_i,
    output logic [ADDR_W-1:0] ptr_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] low_next;

    assign low_next = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
    assign ptr_o    = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (op_i)
                PTR_LOAD:     ptr_q <= load_i;
                PTR_PAGE_INC: ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], low_next};
                PTR_LIN_INC:  ptr_q <= ptr_q + ADDR_W'(1);
                default:      ptr_q <= ptr_q;
            endcase
        end
    end

    AST_PAGE_ROW_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_i == PTR_PAGE_INC) |=>
            (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]))); // R5

endmodule

// File: rtl/tws_mem_target.sv
module tws_mem_target
    import tws_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int UP_W      = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        sel_i,
    output logic              sda_pull_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              wr_req_o,
    input  logic              wr_done_i
);

    tws_bus_ev_t       ev;
    tws_state_t        state;
    logic [3:0]        bitcnt;
    logic [7:0]        rx;
    logic [6:0]        tx;
    logic              pull;
    logic              rw;
    logic [2:0]        dev_hi;
    logic              wrote;
    logic              pending;
    logic              we_q;
    logic [7:0]        wdata_q;
    ptr_op_t           ptr_op;
    logic [ADDR_W-1:0] ptr_load;
    logic [ADDR_W-1:0] ptr;
    logic              dev_ok;

    tws_line_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    tws_addr_ptr #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op_i  (ptr_op),
        .load_i(ptr_load),
        .ptr_o (ptr)
    );

    assign ptr_load = ADDR_W'({dev_hi, rx});
    assign dev_ok   = (rx[7:4] == DEV_TYPE) && sel_match(rx[3:1], sel_i, UP_W) && !pending;

    always_comb begin
        ptr_op = PTR_HOLD;
        if (ev.fall && state != ST_IDLE) begin
            if (bitcnt == 4'd8 && state == ST_WADDR)
                ptr_op = PTR_LOAD;
            else if (bitcnt == 4'd9 && state == ST_WDATA)
                ptr_op = PTR_PAGE_INC;
            else if (bitcnt == 4'd9 && ((state == ST_DEV && rw) ||
                                         (state == ST_RDATA && !rx[0])))
                ptr_op = PTR_LIN_INC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            rx      <= '0;
            tx      <= '0;
            pull    <= 1'b0;
            rw      <= 1'b0;
            dev_hi  <= '0;
            wrote   <= 1'b0;
            pending <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= 1'b0;
            if (wr_done_i) pending <= 1'b0;
            if (ev.stop) begin
                if (state == ST_WDATA && wrote) pending <= 1'b1;
                state  <= ST_IDLE;
                bitcnt <= '0;
                pull   <= 1'b0;
                wrote  <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                pull   <= 1'b0;
                wrote  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (ev.rise) begin
                    rx     <= {rx[6:0], ev.sda};
                    bitcnt <= bitcnt + 4'd1;
                end else if (ev.fall) begin
                    if (bitcnt == 4'd8) begin
                        unique case (state)
                            ST_DEV: begin
                                if (dev_ok) begin
                                    pull   <= 1'b1;
                                    rw     <= rx[0];
                                    dev_hi <= rx[3:1];
                                end else begin
                                    state  <= ST_IDLE;
                                    bitcnt <= '0;
                                    pull   <= 1'b0;
                                end
                            end
                            ST_WADDR: pull <= 1'b1;
                            ST_WDATA: begin
                                pull    <= 1'b1;
                                we_q    <= 1'b1;
                                wdata_q <= rx;
                                wrote   <= 1'b1;
                            end
                            default: pull <= 1'b0;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        unique case (state)
                            ST_DEV: begin
                                if (rw) begin
                                    state <= ST_RDATA;
                                    tx    <= mem_rdata_i[6:0];
                                    pull  <= ~mem_rdata_i[7];
                                end else begin
                                    state <= ST_WADDR;
                                    pull  <= 1'b0;
                                end
                            end
                            ST_WADDR: begin
                                state <= ST_WDATA;
                                pull  <= 1'b0;
                            end
                            ST_RDATA: begin
                                if (!rx[0]) begin
                                    tx   <= mem_rdata_i[6:0];
                                    pull <= ~mem_rdata_i[7];
                                end else begin
                                    state <= ST_IDLE;
                                    pull  <= 1'b0;
                                end
                            end
                            default: pull <= 1'b0;
                        endcase
                    end else if (state == ST_RDATA && bitcnt != 4'd0) begin
                        pull <= ~tx[6];
                        tx   <= {tx[5:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sda_pull_o  = pull;
    assign mem_we_o    = we_q;
    assign mem_addr_o  = ptr;
    assign mem_wdata_o = wdata_q;
    assign wr_req_o    = pending;

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && ev.fall && bitcnt == 4'd8 && pending) |=>
            (state == ST_IDLE && !sda_pull_o)); // R7

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !ev.scl); // R8

    AST_WRITE_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (state == ST_WDATA)); // R5

    AST_START_REARMS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ev.start)) |-> (state == ST_DEV && bitcnt == 4'd0)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_done_i) |=> wr_req_o); // R6

endmodule

// File: tb/tws_mem_target_tb_top.sv
module tws_mem_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int MEM        = 512;
    localparam int PG         = 16;
    localparam int AW         = 9;
    localparam int DONE_DELAY = 600;
    localparam int N_VEC      = 6;
    // {address, data}: single-byte write then random read back
    localparam logic [16:0] VEC [N_VEC] = '{
        {9'h000, 8'hA1}, {9'h0FF, 8'h3C}, {9'h100, 8'h7E},
        {9'h1FF, 8'hC5}, {9'h155, 8'h00}, {9'h0AA, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b1;
    logic          host_sda = 1'b1;
    logic          line;
    logic [2:0]    sel = 3'b101;
    logic          sda_pull;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          wr_req;
    logic          wr_done;
    logic [7:0]    ram [MEM];
    logic [7:0]    exp_mem [MEM];
    int            busy_cnt;
    int            checks = 0;
    int            errors = 0;
    logic [AW-1:0] nxt;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign line = host_sda & ~sda_pull;

    tws_mem_target #(.MEM_BYTES(MEM), .PAGE_BYTES(PG)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .sel_i(sel),
        .sda_pull_o(sda_pull), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .wr_req_o(wr_req), .wr_done_i(wr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM; i++) ram[i] <= 8'((i * 37 + 11) & 255);
            mem_rdata <= '0;
        end else begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            wr_done  <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            if (wr_req && !wr_done) begin
                if (busy_cnt == DONE_DELAY) begin
                    wr_done  <= 1'b1;
                    busy_cnt <= 0;
                end else busy_cnt <= busy_cnt + 1;
            end
        end
    end

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic h_start();
        host_sda = 1'b1; wait_c(Q);
        scl = 1'b1;      wait_c(Q);
        host_sda = 1'b0; wait_c(Q);
        scl = 1'b0;      wait_c(Q);
    endtask

    task automatic h_stop();
        host_sda = 1'b0; wait_c(Q);
        scl = 1'b1;      wait_c(Q);
        host_sda = 1'b1; wait_c(2*Q);
    endtask

    task automatic h_bit_out(input logic b);
        host_sda = b; wait_c(Q);
        scl = 1'b1;   wait_c(2*Q);
        scl = 1'b0;   wait_c(Q);
    endtask

    task automatic h_bit_in(output logic b);
        host_sda = 1'b1; wait_c(Q);
        scl = 1'b1;      wait_c(Q);
        b = line;        wait_c(Q);
        scl = 1'b0;      wait_c(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) h_bit_out(v[i]);
        h_bit_in(a);
        acked = !a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) h_bit_in(v[i]);
        h_bit_out(!give_ack);
    endtask

    function automatic logic [7:0] dev(input logic [8:0] a, input logic rd);
        return {4'b1010, 2'b10, a[8], rd};
    endfunction

    task automatic wait_done();
        while (wr_req) @(negedge clk);
        wait_c(4);
    endtask

    // Write n bytes starting at a, values first+k; updates model with page wrap.
    task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] first);
        logic ak;
        h_start();
        send_byte(dev(a, 1'b0), ak); chk8("R2 write dev ack", {7'd0, ak}, 8'd1);
        send_byte(a[7:0], ak);       chk8("R4 word addr ack", {7'd0, ak}, 8'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(first + 8'(k), ak);
            chk8("R5 data ack", {7'd0, ak}, 8'd1);
            exp_mem[{a[8:4], 4'(a[3:0] + 4'(k))}] = first + 8'(k);
        end
        h_stop();
        nxt = {a[8:4], 4'(a[3:0] + 4'(n))};
    endtask

    task automatic rand_read(input string req, input logic [8:0] a, input int n);
        logic ak;
        logic [7:0] v;
        h_start();
        send_byte(dev(a, 1'b0), ak); chk8({req, " dummy dev ack"}, {7'd0, ak}, 8'd1);
        send_byte(a[7:0], ak);       chk8({req, " dummy addr ack"}, {7'd0, ak}, 8'd1);
        h_start();
        send_byte(dev(a, 1'b1), ak); chk8({req, " read dev ack"}, {7'd0, ak}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk8(req, v, exp_mem[9'(a + 9'(k))]);
        end
        h_stop();
        nxt = 9'(a + 9'(n));
    endtask

    initial begin
        for (int i = 0; i < MEM; i++) exp_mem[i] = 8'((i * 37 + 11) & 255);
    end

    initial begin
        wait_c(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] v;
        wait_c(5);
        rst = 1'b0;
        wait_c(5);
        // R1: reset state
        chk8("R1 reset pull", {7'd0, sda_pull}, 8'd0);
        chk8("R1 reset req", {7'd0, wr_req}, 8'd0);
        chk8("R1 reset we", {7'd0, mem_we}, 8'd0);

        // Table: byte write, wait for write cycle, read back (R3 upper bit, R4, R5)
        for (int i = 0; i < N_VEC; i++) begin
            do_write(VEC[i][16:8], 1, VEC[i][7:0]);
            wait_done();
            rand_read("R3 R4 table readback", VEC[i][16:8], 1);
        end

        // R5: page write of 20 bytes starting at offset 12 wraps in page 0x130
        do_write(9'h13C, 20, 8'h40);
        chk8("R6 request after data write", {7'd0, wr_req}, 8'd1);
        // R7: polling while busy gets no acknowledge
        h_start();
        send_byte(dev(9'h000, 1'b0), ak);
        chk8("R7 busy poll nack", {7'd0, ak}, 8'd0);
        h_stop();
        chk8("R6 request held", {7'd0, wr_req}, 8'd1);
        wait_done();
        h_start();
        send_byte(dev(9'h000, 1'b1), ak);
        chk8("R7 ack after done", {7'd0, ak}, 8'd1);
        recv_byte(1'b0, v);
        h_stop();
        rand_read("R5 page wrap content", 9'h130, 16);
        chk8("R5 next page untouched", exp_mem[9'h140], 8'((9'h140 * 37 + 11) & 255));

        // R9: current address read continues after last access (0x140)
        h_start();
        send_byte(dev(9'h000, 1'b1), ak);
        chk8("R9 cur read ack", {7'd0, ak}, 8'd1);
        recv_byte(1'b0, v);
        h_stop();
        chk8("R9 current address data", v, exp_mem[9'h140]);

        // R8: sequential read across the top of memory
        rand_read("R8 wrap read", 9'h1FE, 4);
        chk8("R1 released after stop", {7'd0, line}, 8'd1);

        // R6: dummy write raises no request
        h_start();
        send_byte(dev(9'h020, 1'b0), ak);
        send_byte(8'h20, ak);
        h_stop();
        wait_c(10);
        chk8("R6 no request on dummy write", {7'd0, wr_req}, 8'd0);

        // R3: select mismatch and R2: wrong type code
        h_start();
        send_byte(8'b1010_0100, ak);
        chk8("R3 select mismatch nack", {7'd0, ak}, 8'd0);
        h_stop();
        h_start();
        send_byte(8'b1011_1000, ak);
        chk8("R2 type mismatch nack", {7'd0, ak}, 8'd0);
        h_stop();

        // R10: start in the middle of a data byte discards it
        h_start();
        send_byte(dev(9'h020, 1'b0), ak);
        send_byte(8'h20, ak);
        for (int i = 0; i < 5; i++) h_bit_out(1'b0);
        h_start();
        send_byte(dev(9'h020, 1'b1), ak);
        chk8("R10 restart ack", {7'd0, ak}, 8'd1);
        recv_byte(1'b0, v);
        h_stop();
        chk8("R10 partial byte not written", v, exp_mem[9'h020]);
        chk8("R10 no request after abort", {7'd0, wr_req}, 8'd0);
        // R10: stop mid device byte, then a fresh transfer works
        h_start();
        for (int i = 0; i < 3; i++) h_bit_out(1'b1);
        h_stop();
        rand_read("R10 after stop abort", 9'h021, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule